// File: doc/BRIEF.md
# Parallel Port Host Register File

This block is the host-facing register set of a bidirectional printer-style parallel port. A small bus with a two-bit offset reaches three registers: a data byte, a read-only status view and a control byte. The block drives the eight data pins with an output enable and four open-drain control lines. It reads back the five printer status inputs and the levels on the control lines, and raises an interrupt when the acknowledge line rises.

Every pin input passes through a `SYNC_STAGES`-deep synchronizer. A pin change therefore shows up in reads and edge detection `SYNC_STAGES` clocks later. Register reads are combinational from the offset while `sel` is high. A write takes effect on the clock edge where `sel` and `wr` are both high. A status read clears the interrupt flag on the edge where `sel` is high and `wr` is low.

Top module: `pport_regs`

## Requirements
- R1: After reset the data register and the control register are 0. The data pins are driven (`pd_oe`=1) with `pd_out`=0x00, `ctl_pull_low`=4'b0100, and `irq`=0.
- R2: A write to offset 0 stores the byte. It appears on `pd_out` after that edge. While control bit 5 is 0, a read of offset 0 returns the stored byte.
- R3: While control bit 5 is 1, `pd_oe` is 0 and a read of offset 0 returns the synchronized `pd_in` byte. Writes to offset 0 are still stored and appear on `pd_out` once bit 5 returns to 0.
- R4: A read of offset 1 returns the following bits. Bit 7 is the inverse of `busy_pin`. Bit 6 is `nack_pin`. Bit 5 is `paper_pin`. Bit 4 is `select_pin`. Bit 3 is `fault_n_pin`. Bit 2 is the inverse of the interrupt flag. Bits 1:0 read 1.
- R5: A write to offset 1 changes no register and no output.
- R6: `ctl_pull_low[i]`=1 pulls control line i low. Lines 0, 1 and 3 follow control bits 0, 1 and 3 directly, and line 2 follows the inverse of bit 2. Writing 0x04 releases all four lines.
- R7: A read of offset 2 returns the following bits. Bits 3:0 are the line levels `ctl_in` mapped back as {~ctl_in[3], ctl_in[2], ~ctl_in[1], ~ctl_in[0]}. Bits 5:4 are the stored control bits. Bits 7:6 read 1 and ignore writes.
- R8: While control bit 4 is 1, a low-to-high change on `nack_pin` sets the interrupt flag. `irq` then goes to 1 and status bit 2 reads 0.
- R9: A falling `nack_pin`, or a rising `nack_pin` while control bit 4 is 0, leaves the flag clear.
- R10: A read of offset 1 clears the flag after that edge. A rising edge detected in the same cycle wins over the clear.
- R11: `irq` is the flag gated by control bit 4. Clearing bit 4 forces `irq` to 0 but keeps the flag, so setting bit 4 again raises `irq` again.
- R12: Offset 3 reads 0xFF, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus access in this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pd_out | output | 8 | Data pin drive value |
| pd_oe | output | 1 | Data pin output enable |
| pd_in | input | 8 | Data pin levels |
| ctl_pull_low | output | 4 | Open-drain pull-down per control line |
| ctl_in | input | 4 | Resolved control line levels |
| busy_pin | input | 1 | Printer busy |
| nack_pin | input | 1 | Acknowledge, active low |
| paper_pin | input | 1 | Paper out |
| select_pin | input | 1 | Printer selected |
| fault_n_pin | input | 1 | Error, active low |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches the following on every cycle:
- the data output only moves on a data write, and then takes the written value;
- status writes leave every output untouched;
- the output enable follows bit 5 of each control write;
- clearing bit 4 drops `irq`;
- a status read without a coincident acknowledge edge clears the flag;
- reserved status bits read as 1.

Only the bench scenarios show the remaining behaviour:
- the bit-level inversions of the status and control views;
- the open-drain readback through an external pull-down;
- which acknowledge edge sets the flag;
- the flag surviving a masked period.

// File: rtl/pport_regs.sv
module pport_regs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  input  logic [7:0] pd_in,
  output logic [3:0] ctl_pull_low,
  input  logic [3:0] ctl_in,
  input  logic       busy_pin,
  input  logic       nack_pin,
  input  logic       paper_pin,
  input  logic       select_pin,
  input  logic       fault_n_pin,
  output logic       irq
);
  localparam int IN_W = 8 + 4 + 5;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;

  logic [7:0] data_q;
  logic [5:0] ctrl_q;
  logic       flag_q;
  logic       nack_d;
  logic [SYNC_STAGES-1:0][IN_W-1:0] sync_q;
  logic [IN_W-1:0] s;

  wire [IN_W-1:0] raw = {pd_in, ctl_in, busy_pin, nack_pin, paper_pin, select_pin, fault_n_pin};

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s = sync_q[SYNC_STAGES-1];

  wire [7:0] pd_s    = s[16:9];
  wire [3:0] ctl_s   = s[8:5];
  wire       busy_s  = s[4];
  wire       nack_s  = s[3];
  wire       paper_s = s[2];
  wire       slct_s  = s[1];
  wire       fault_s = s[0];

  wire wr_en     = sel && wr;
  wire stat_rd   = sel && !wr && (addr == OFS_STAT);
  wire nack_rise = nack_s && !nack_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      nack_d <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      nack_d <= nack_s;
      if (wr_en && addr == OFS_DATA) data_q <= wdata;
      if (wr_en && addr == OFS_CTRL) ctrl_q <= wdata[5:0];
      if (ctrl_q[4] && nack_rise) flag_q <= 1'b1;
      else if (stat_rd)          flag_q <= 1'b0;
    end
  end

  assign pd_out       = data_q;
  assign pd_oe        = !ctrl_q[5];
  assign ctl_pull_low = {ctrl_q[3], ~ctrl_q[2], ctrl_q[1], ctrl_q[0]};
  assign irq          = flag_q && ctrl_q[4];

  always_comb begin
    case (addr)
      OFS_DATA: rdata = ctrl_q[5] ? pd_s : data_q;
      OFS_STAT: rdata = {~busy_s, nack_s, paper_s, slct_s, fault_s, ~flag_q, 2'b11};
      OFS_CTRL: rdata = {2'b11, ctrl_q[5:4], ~ctl_s[3], ctl_s[2], ~ctl_s[1], ~ctl_s[0]};
      default:  rdata = 8'hFF;
    endcase
  end
endmodule

module pport_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pd_out,
  input logic       pd_oe,
  input logic [3:0] ctl_pull_low,
  input logic       irq,
  input logic       flag_q,
  input logic       nack_rise
);
  p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'd0) |=> pd_out == $past(wdata));
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr && addr == 2'd0) |=> $stable(pd_out));
  p_oe_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'd2) |=> pd_oe == !$past(wdata[5]));
  p_stat_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr == 2'd1) |-> rdata[1:0] == 2'b11);
  p_stat_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'd1) |=> $stable(pd_out) && $stable(pd_oe) && $stable(ctl_pull_low));
  p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr == 2'd1 && !nack_rise) |=> !flag_q);
  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 2'd2 && !wdata[4]) |=> !irq);
endmodule

bind pport_regs pport_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pd_out(pd_out), .pd_oe(pd_oe), .ctl_pull_low(ctl_pull_low),
  .irq(irq), .flag_q(flag_q), .nack_rise(nack_rise)
);

// File: tb/pport_regs_bench.sv
module pport_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pd_out, pd_in = '0;
  logic pd_oe, irq;
  logic [3:0] ctl_pull_low, ctl_in, ext_pull = '0;
  logic busy_pin = 0, nack_pin = 1, paper_pin = 0, select_pin = 1, fault_n_pin = 1;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ctl_in = ~(ctl_pull_low | ext_pull);

  pport_regs u_pport_regs (.*);

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pd_oe", {7'd0, pd_oe}, 8'h01);
    check("R1 pd_out", pd_out, 8'h00);
    check("R1 pull", {4'd0, ctl_pull_low}, 8'h04);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd_reg(2'd2, d); check("R1 ctrl", d, 8'hC0);
    rd_reg(2'd0, d); check("R1 data", d, 8'h00);
  endtask

  task automatic t_forward();
    logic [7:0] d;
    wr_reg(2'd0, 8'hA5);
    check("R2 pd_out", pd_out, 8'hA5);
    rd_reg(2'd0, d); check("R2 read", d, 8'hA5);
    wr_reg(2'd0, 8'h3C);
    rd_reg(2'd0, d); check("R2 read2", d, 8'h3C);
  endtask

  task automatic t_reverse();
    logic [7:0] d;
    wr_reg(2'd2, 8'h24);
    check("R3 oe off", {7'd0, pd_oe}, 8'h00);
    pd_in = 8'h5A; settle();
    rd_reg(2'd0, d); check("R3 pins", d, 8'h5A);
    wr_reg(2'd0, 8'h81);
    rd_reg(2'd0, d); check("R3 still pins", d, 8'h5A);
    check("R3 oe still off", {7'd0, pd_oe}, 8'h00);
    wr_reg(2'd2, 8'h04);
    check("R3 oe on", {7'd0, pd_oe}, 8'h01);
    check("R3 stored", pd_out, 8'h81);
    rd_reg(2'd0, d); check("R3 fwd read", d, 8'h81);
  endtask

  task automatic t_status();
    logic [7:0] d;
    settle();
    rd_reg(2'd1, d); check("R4 idle", d, 8'hDF);
    busy_pin = 1; nack_pin = 0; paper_pin = 1; select_pin = 0; fault_n_pin = 0; settle();
    rd_reg(2'd1, d); check("R4 pattern1", d, 8'h27);
    busy_pin = 0; nack_pin = 1; paper_pin = 1; select_pin = 1; fault_n_pin = 0; settle();
    rd_reg(2'd1, d); check("R4 pattern2", d, 8'hF7);
    paper_pin = 0; fault_n_pin = 1; settle();
  endtask

  task automatic t_stat_ro();
    logic [7:0] d;
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd1, 8'hFF);
    check("R5 pd_out", pd_out, 8'h81);
    check("R5 pull", {4'd0, ctl_pull_low}, 8'h00);
    rd_reg(2'd1, d); check("R5 status", d, 8'hDF);
    rd_reg(2'd2, d); check("R5 ctrl", d, 8'hC4);
  endtask

  task automatic t_ctl_out();
    wr_reg(2'd2, 8'h0B);
    check("R6 0B", {4'd0, ctl_pull_low}, 8'h0F);
    wr_reg(2'd2, 8'h0F);
    check("R6 0F", {4'd0, ctl_pull_low}, 8'h0B);
    wr_reg(2'd2, 8'h04);
    check("R6 release", {4'd0, ctl_pull_low}, 8'h00);
  endtask

  task automatic t_ctl_in();
    logic [7:0] d;
    wr_reg(2'd2, 8'hE4); settle();
    rd_reg(2'd2, d); check("R7 bits76 and 54", d, 8'hE4);
    wr_reg(2'd2, 8'h04);
    ext_pull = 4'b1010; settle();
    rd_reg(2'd2, d); check("R7 external pull", d, 8'hCE);
    ext_pull = 4'b0000; settle();
    rd_reg(2'd2, d); check("R7 released", d, 8'hC4);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr_reg(2'd2, 8'h14);
    nack_pin = 0; settle();
    check("R9 falling", {7'd0, irq}, 8'h00);
    nack_pin = 1; settle();
    check("R8 irq", {7'd0, irq}, 8'h01);
    rd_reg(2'd1, d); check("R8 status bit2", d, 8'hDB);
    check("R10 cleared", {7'd0, irq}, 8'h00);
    rd_reg(2'd1, d); check("R10 status", d, 8'hDF);
    wr_reg(2'd2, 8'h04);
    nack_pin = 0; settle(); nack_pin = 1; settle();
    wr_reg(2'd2, 8'h14);
    check("R9 disabled", {7'd0, irq}, 8'h00);
    rd_reg(2'd1, d); check("R9 status", d, 8'hDF);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    nack_pin = 0; settle(); nack_pin = 1; settle();
    check("R11 set", {7'd0, irq}, 8'h01);
    wr_reg(2'd2, 8'h04);
    check("R11 masked", {7'd0, irq}, 8'h00);
    wr_reg(2'd2, 8'h14);
    check("R11 unmasked", {7'd0, irq}, 8'h01);
    rd_reg(2'd1, d); check("R11 flag kept", d, 8'hDB);
    check("R10 after read", {7'd0, irq}, 8'h00);
    wr_reg(2'd2, 8'h04);
  endtask

  task automatic t_ofs3();
    logic [7:0] d;
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd3, d); check("R12 read", d, 8'hFF);
    rd_reg(2'd2, d); check("R12 ctrl", d, 8'hC4);
    rd_reg(2'd0, d); check("R12 data", d, 8'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    t_reset();
    t_forward();
    t_reverse();
    t_status();
    t_stat_ro();
    t_ctl_out();
    t_ctl_in();
    t_irq();
    t_mask();
    t_ofs3();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule